// File: doc/BRIEF.md
# Counter-Mode Block Counter with Programmable Wrap Width

This block keeps the running 128-bit counter block used by counter-mode encryption. The host loads an initial counter value together with a wrap exponent M. The current counter is presented on an output for the block cipher to encrypt. Each block-advance strobe moves the counter on by one. The increment is confined to the low M bits: they wrap modulo 2^M, and everything above bit M-1 stays as loaded.

The block also holds the XOR stage that follows the cipher. The encrypted counter block (the keystream) is combined with an input data block. The same path serves both directions: plaintext in gives ciphertext out, and ciphertext in gives plaintext out. The cipher core itself sits outside this block.

Top module: `ctrm_counter`

## Requirements
- R1: After reset the counter output is all zeros, the stored wrap exponent is 128, and the invalid-exponent flag is low.
- R2: A load strobe sampled at a clock edge makes the counter output equal the supplied initial value from the next cycle on. The exponent input is stored at the same edge.
- R3: While the advance strobe is high, the counter output still shows the pre-increment value for the current block. After the edge the low M bits hold that value plus one, modulo 2^M.
- R4: An advance never changes any counter bit at position M or above.
- R5: When the low M bits are all ones, an advance wraps them to zero with no carry into bit M.
- R6: The exponent input is the wrap width in bits, as an unsigned 8-bit number. The legal values are 8, 16, …, 128. With M = 128 the whole counter takes part and wraps from all ones to zero.
- R7: A stored exponent that is not a multiple of 8, or that lies outside 8 to 128, raises the invalid-exponent flag. While the flag is high, advance strobes leave the counter unchanged.
- R8: When load and advance are high in the same cycle, the load wins. The counter takes the initial value, not an incremented one.
- R9: The data output is the bitwise XOR of the keystream and data inputs in the same cycle. Feeding the output back with the same keystream returns the original data.
- R10: With neither strobe high, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Load initial counter and wrap exponent |
| init_i | input | 128 | Initial counter value |
| mexp_i | input | 8 | Wrap exponent M, in bits |
| adv_i | input | 1 | Block-advance strobe |
| ks_i | input | 128 | Keystream block (encrypted counter) |
| din_i | input | 128 | Plaintext or ciphertext block |
| ctr_o | output | 128 | Current counter block |
| dout_o | output | 128 | ks_i XOR din_i |
| m_bad_o | output | 1 | Stored wrap exponent is invalid |

## Verification
The two functions that can fall in the same cycle are a load and a block advance. The bench raises both strobes across one edge, starting from a counter value that would visibly change if incremented. It then requires the loaded value, and not that value plus one, in the next cycle. A second meeting point is an advance that arrives while an invalid exponent is stored. In that case the counter must read the same value before and after the edge, and the flag must stay high.

// File: rtl/ctrm_pkg.sv
package ctrm_pkg;

    localparam int unsigned CTRM_CTR_W  = 128;
    localparam int unsigned CTRM_MEXP_W = 8;
    localparam int unsigned CTRM_BYTE_W = 8;

    // Legal wrap exponent: whole bytes, at least one byte, at most the counter width
    function automatic logic mexp_legal(input logic [CTRM_MEXP_W-1:0] m, input int unsigned ctr_w);
        return (int'(m) % CTRM_BYTE_W == 0) && (int'(m) >= CTRM_BYTE_W) && (int'(m) <= int'(ctr_w));
    endfunction

endpackage

// File: rtl/ctrm_mask.sv
module ctrm_mask
    import ctrm_pkg::*;
#(
    parameter int unsigned CTR_W  = CTRM_CTR_W,
    parameter int unsigned MEXP_W = CTRM_MEXP_W
) (
    input  logic [MEXP_W-1:0] mexp_i,
    output logic [CTR_W-1:0]  mask_o,
    output logic              legal_o
);
    localparam int unsigned NBYTES = CTR_W / CTRM_BYTE_W;

    assign legal_o = mexp_legal(mexp_i, CTR_W);

    // Byte lane b counts when M reaches past its lowest bit
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign mask_o[b*CTRM_BYTE_W +: CTRM_BYTE_W] =
            (legal_o && (int'(mexp_i) > b * CTRM_BYTE_W)) ? {CTRM_BYTE_W{1'b1}} : '0;
    end
endmodule

// File: rtl/ctrm_step.sv
module ctrm_step
    import ctrm_pkg::*;
#(
    parameter int unsigned CTR_W = CTRM_CTR_W
) (
    input  logic [CTR_W-1:0] cur_i,
    input  logic [CTR_W-1:0] mask_i,
    output logic [CTR_W-1:0] nxt_o
);
    logic [CTR_W-1:0] inc;

    // Any carry out of the masked field is discarded by the merge below
    assign inc   = cur_i + CTR_W'(1);
    assign nxt_o = (cur_i & ~mask_i) | (inc & mask_i);
endmodule

// File: rtl/ctrm_xor.sv
module ctrm_xor
    import ctrm_pkg::*;
#(
    parameter int unsigned CTR_W = CTRM_CTR_W
) (
    input  logic [CTR_W-1:0] ks_i,
    input  logic [CTR_W-1:0] din_i,
    output logic [CTR_W-1:0] dout_o
);
    localparam int unsigned NBYTES = CTR_W / CTRM_BYTE_W;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign dout_o[b*CTRM_BYTE_W +: CTRM_BYTE_W] =
            ks_i[b*CTRM_BYTE_W +: CTRM_BYTE_W] ^ din_i[b*CTRM_BYTE_W +: CTRM_BYTE_W];
    end
endmodule

// File: rtl/ctrm_counter.sv
module ctrm_counter
    import ctrm_pkg::*;
#(
    parameter int unsigned CTR_W  = CTRM_CTR_W,
    parameter int unsigned MEXP_W = CTRM_MEXP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CTR_W-1:0]  init_i,
    input  logic [MEXP_W-1:0] mexp_i,
    input  logic              adv_i,
    input  logic [CTR_W-1:0]  ks_i,
    input  logic [CTR_W-1:0]  din_i,
    output logic [CTR_W-1:0]  ctr_o,
    output logic [CTR_W-1:0]  dout_o,
    output logic              m_bad_o
);
    typedef struct packed {
        logic [CTR_W-1:0]  ctr;
        logic [MEXP_W-1:0] mexp;
    } state_t;

    state_t st_d, st_q;

    logic [CTR_W-1:0] mask;
    logic             legal;
    logic [CTR_W-1:0] step_nxt;

    ctrm_mask #(.CTR_W(CTR_W), .MEXP_W(MEXP_W)) i_mask (
        .mexp_i  (st_q.mexp),
        .mask_o  (mask),
        .legal_o (legal)
    );

    ctrm_step #(.CTR_W(CTR_W)) i_step (
        .cur_i  (st_q.ctr),
        .mask_i (mask),
        .nxt_o  (step_nxt)
    );

    ctrm_xor #(.CTR_W(CTR_W)) i_xor (
        .ks_i   (ks_i),
        .din_i  (din_i),
        .dout_o (dout_o)
    );

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.ctr  = init_i;
            st_d.mexp = mexp_i;
        end else if (adv_i && legal) begin
            st_d.ctr = step_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctr  <= '0;
            st_q.mexp <= MEXP_W'(CTR_W);
        end else begin
            st_q <= st_d;
        end
    end

    assign ctr_o   = st_q.ctr;
    assign m_bad_o = !legal;

    assert_load_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (ctr_o == $past(init_i)));

    assert_upper_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i) |=> ((ctr_o & ~$past(mask)) == ($past(ctr_o) & ~$past(mask))));

    assert_bad_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && m_bad_o) |=> $stable(ctr_o));

    assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_i) |=> $stable(ctr_o));

    assert_mask_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !m_bad_o |-> ($countones(mask) == int'(st_q.mexp)));
endmodule

// File: tb/test_ctrm_counter.sv
`timescale 1ns/1ps
module test_ctrm_counter;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_i = 1'b0;
    logic [127:0] init_i = '0;
    logic [7:0]   mexp_i = '0;
    logic         adv_i = 1'b0;
    logic [127:0] ks_i = '0;
    logic [127:0] din_i = '0;
    logic [127:0] ctr_o;
    logic [127:0] dout_o;
    logic         m_bad_o;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    ctrm_counter i_ctrm_counter (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .init_i(init_i), .mexp_i(mexp_i),
        .adv_i(adv_i), .ks_i(ks_i), .din_i(din_i), .ctr_o(ctr_o), .dout_o(dout_o),
        .m_bad_o(m_bad_o)
    );

    localparam int NV = 9;
    localparam logic [127:0] V_INIT [NV] = '{
        128'h0,
        128'hABCDEF_FE,
        128'h1234_FFFF,
        {128{1'b1}},
        128'h5555555555555555_FFFFFFFFFFFFFFFE,
        128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FF00FFFF,
        128'h77,
        128'h99,
        128'h42
    };
    localparam logic [7:0] V_M [NV] = '{8'd128, 8'd8, 8'd16, 8'd128, 8'd64, 8'd24, 8'd12, 8'd0, 8'd136};
    localparam int V_N [NV] = '{3, 3, 1, 1, 2, 2, 4, 1, 2};
    localparam logic [127:0] V_EXP [NV] = '{
        128'h3,
        128'hABCDEF_01,
        128'h1234_0000,
        128'h0,
        128'h5555555555555555_0000000000000000,
        128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FF010001,
        128'h77,
        128'h99,
        128'h42
    };
    localparam logic V_BAD [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
    localparam string V_REQ [NV] = '{"R3", "R5", "R5", "R6", "R4", "R3", "R7", "R7", "R7"};

    task automatic check128(input string req, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check1(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [127:0] v, input logic [7:0] m);
        @(negedge clk);
        load_i = 1'b1; init_i = v; mexp_i = m;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic do_adv(input int n);
        @(negedge clk);
        adv_i = 1'b1;
        for (int k = 0; k < n; k++) @(negedge clk);
        adv_i = 1'b0;
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check128("R1", ctr_o, '0);
        check1("R1", m_bad_o, 1'b0);
        rst_n = 1'b1;
        // R1: default exponent 128 lets the full counter advance
        do_adv(1);
        check128("R1", ctr_o, 128'h1);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            do_load(V_INIT[i], V_M[i]);
            check128("R2", ctr_o, V_INIT[i]);
            do_adv(V_N[i]);
            check128(V_REQ[i], ctr_o, V_EXP[i]);
            check1(V_REQ[i], m_bad_o, V_BAD[i]);
        end

        // R3: pre-increment value visible during the strobe cycle
        do_load(128'hF0, 8'd8);
        @(negedge clk);
        adv_i = 1'b1;
        #1 check128("R3", ctr_o, 128'hF0);
        @(negedge clk);
        adv_i = 1'b0;
        check128("R3", ctr_o, 128'hF1);

        // R10: no strobe holds
        repeat (3) @(negedge clk);
        check128("R10", ctr_o, 128'hF1);

        // R8: load beats a simultaneous advance
        @(negedge clk);
        load_i = 1'b1; adv_i = 1'b1; init_i = 128'h500; mexp_i = 8'd16;
        @(negedge clk);
        load_i = 1'b0; adv_i = 1'b0;
        check128("R8", ctr_o, 128'h500);

        // R7: advance under invalid exponent keeps counter and flag
        do_load(128'h1FF, 8'd129);
        do_adv(2);
        check128("R7", ctr_o, 128'h1FF);
        check1("R7", m_bad_o, 1'b1);
        // R7: reloading a legal exponent clears the flag
        do_load(128'h1FF, 8'd8);
        check1("R7", m_bad_o, 1'b0);
        do_adv(1);
        check128("R5", ctr_o, 128'h100);

        // R9: XOR path and its inverse
        ks_i  = 128'hDEADBEEF_01234567_89ABCDEF_0F0F0F0F;
        din_i = 128'h11111111_22222222_33333333_44444444;
        #1 check128("R9", dout_o, 128'hCFBCAFFE_23016745_BA98FEDC_4B4B4B4B);
        din_i = 128'hCFBCAFFE_23016745_BA98FEDC_4B4B4B4B;
        #1 check128("R9", dout_o, 128'h11111111_22222222_33333333_44444444);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule